// File: doc/BRIEF.md
# Banked DRAM Page State Tracker

This block is the device-side model of a multi-bank DRAM that takes compound command words. Each accepted command carries an activate flag, an auto-precharge flag, a six-bit opcode, a bank, a row and a column. The block sorts the command into one of five classes: column read, column write, register read, register write or illegal. It keeps one open-row record per bank, and from the request and that record it works out whether the access is a page hit, needs an activate, or needs a precharge followed by an activate.

Legal column accesses act on a small behavioural array with one 64-bit octbyte per bank, row and column. Writes can be full, byte-masked or bit-masked. Register accesses are only decoded and reported. Every accepted command gets a registered response one clock after acceptance. The per-bank open flags are visible at all times.

Top module: `dram_page_tracker`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `rsp_valid` is 0 and every bit of `bank_open` is 0. A clock with `cmd_valid` low produces `rsp_valid` 0 on the next clock.
- R2: The decode uses `cmd_op[1:0]` (00 read, 01 write, 10 register read, 11 register write). A read is legal only with `cmd_op[5:3]` = 0. Register accesses are legal only with `cmd_op[2]` = 1 and both flags low; a register read also needs `cmd_op[5:3]` = 0 and a register write needs `cmd_op[5:4]` = 0. Any other command reports class 4 (illegal) with `rsp_err` = 1 and changes no bank state. Class codes are 0 read, 1 write, 2 register read, 3 register write, 4 illegal.
- R3: A column command with `cmd_actv` = 1 to an idle bank reports `rsp_act` = 1, `rsp_pre` = 0 and `rsp_hit` = 0, and leaves the requested row open.
- R4: A column command with `cmd_actv` = 1 whose row equals the bank's open row reports `rsp_hit` = 1 and neither precharge nor activate.
- R5: A column command with `cmd_actv` = 1 whose row differs from the bank's open row reports `rsp_pre` = 1 and `rsp_act` = 1, and the new row becomes the open row.
- R6: A column command with `cmd_actv` = 0 to an open bank reports `rsp_hit` = 1 and accesses the open row; `cmd_row` is ignored.
- R7: A column command with `cmd_actv` = 0 to an idle bank reports `rsp_err` = 1, returns `rsp_rdata` = 0 and neither reads nor writes the array.
- R8: A legal column command with `cmd_auto` = 1 leaves its bank idle afterwards, whatever its activate flag was.
- R9: A legal read returns the stored octbyte at bank, row and column on `rsp_rdata`, together with `rsp_valid`, one clock after acceptance. Other commands return 0.
- R10: A write with `cmd_op[5:4]` = 00 stores all 64 bits of `wr_data` and ignores `wr_mask`.
- R11: A write with `cmd_op[5:4]` not 00 and `cmd_op[2]` = 0 is byte-masked: `wr_mask[i]` enables byte i (bits 8i+7..8i), and disabled bytes keep their old value.
- R12: A write with `cmd_op[5:4]` not 00 and `cmd_op[2]` = 1 is bit-masked: `wr_mask[k]` enables bit k, and disabled bits keep their old value.
- R13: Register reads and writes report their class with no flag set and change no bank state.
- R14: Banks are independent: each keeps its own open row and its own storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command accepted this clock |
| cmd_actv | input | 1 | Activate requested before the column step |
| cmd_auto | input | 1 | Auto-precharge after the column step |
| cmd_op | input | 6 | Opcode bits |
| cmd_bank | input | BANK_W | Bank index |
| cmd_row | input | ROW_W | Row index |
| cmd_col | input | COL_W | Octbyte column index |
| wr_data | input | 64 | Write data |
| wr_mask | input | 64 | Bit enables, or byte enables in bits 7..0 |
| rsp_valid | output | 1 | Response for the command of the previous clock |
| rsp_class | output | 3 | Decoded class code |
| rsp_pre | output | 1 | Precharge of another row was needed |
| rsp_act | output | 1 | Activate was needed |
| rsp_hit | output | 1 | Access hit the open page |
| rsp_err | output | 1 | Illegal command, or column access to an idle bank |
| rsp_rdata | output | 64 | Read data |
| bank_open | output | NUM_BANKS | One bit per bank, set while a row is open |

## Verification
The assertions check on every clock that the response flags agree with each other: a precharge always comes with an activate, and a hit never does. They also check that errors and register accesses leave the bank flags unchanged, that an auto-precharge closes the bank it addressed, and that masked-off bits survive a write. Whether the right row is judged hit, miss or conflict, whether read data matches earlier writes across row switches and banks, and whether the byte and bit mask layouts are right can only be shown by the bench's command sequences.

// File: rtl/dpt_pkg.sv
// Package dpt_pkg
// Shared types of the page state tracker: the command class code and the
// decoded write-mask options. Assumes one octbyte is 64 bits.
package dpt_pkg;

    localparam int OCT_BITS  = 64;
    localparam int OCT_BYTES = OCT_BITS / 8;

    typedef enum logic [2:0] {
        CLS_READ    = 3'd0,
        CLS_WRITE   = 3'd1,
        CLS_REGRD   = 3'd2,
        CLS_REGWR   = 3'd3,
        CLS_ILLEGAL = 3'd4
    } cmd_class_e;

    typedef struct packed {
        cmd_class_e cls;
        logic       mask_en;   // write uses a mask
        logic       bit_mask;  // 1: per-bit mask, 0: per-byte mask
    } dec_t;

endpackage

// File: rtl/dpt_cmd_decode.sv
// Module dpt_cmd_decode
// Pure combinational decode of one command word into a class and the mask
// options. Assumes the opcode layout: bits 1..0 pick the class, bit 2 picks
// bit/byte masking on writes and marks register accesses, bits 5..4 enable
// masking, bit 3 is a broadcast flag with no local effect.
module dpt_cmd_decode
    import dpt_pkg::*;
(
    input  logic       actv_i,
    input  logic       auto_i,
    input  logic [5:0] op_i,
    output dec_t       dec_o
);

    // Classify the opcode and reject reserved combinations.
    always_comb begin
        dec_o.cls      = CLS_ILLEGAL;
        dec_o.mask_en  = 1'b0;
        dec_o.bit_mask = 1'b0;
        unique case (op_i[1:0])
            2'b00: begin
                if (op_i[5:3] == 3'b000) dec_o.cls = CLS_READ;
            end
            2'b01: begin
                dec_o.cls      = CLS_WRITE;
                dec_o.mask_en  = |op_i[5:4];
                dec_o.bit_mask = op_i[2];
            end
            2'b10: begin
                if (op_i[2] && !actv_i && !auto_i && op_i[5:3] == 3'b000)
                    dec_o.cls = CLS_REGRD;
            end
            default: begin
                if (op_i[2] && !actv_i && !auto_i && op_i[5:4] == 2'b00)
                    dec_o.cls = CLS_REGWR;
            end
        endcase
    end

endmodule

// File: rtl/dpt_bank_table.sv
// Module dpt_bank_table
// One open flag and one open-row register per bank. Offers a combinational
// lookup of one bank and takes one update per clock. Assumes the caller
// only updates on legal column accesses.
module dpt_bank_table #(
    parameter  int NUM_BANKS = 2,
    parameter  int ROW_W     = 4,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BANK_W-1:0]    look_bank_i,
    output logic                 look_open_o,
    output logic [ROW_W-1:0]     look_row_o,
    input  logic                 upd_en_i,
    input  logic [BANK_W-1:0]    upd_bank_i,
    input  logic                 upd_open_i,
    input  logic [ROW_W-1:0]     upd_row_i,
    output logic [NUM_BANKS-1:0] open_o
);

    logic [ROW_W-1:0] row_q [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Hold this bank's open flag and row; reset leaves every bank idle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_o[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (upd_en_i && upd_bank_i == BANK_W'(b)) begin
                open_o[b] <= upd_open_i;
                row_q[b]  <= upd_row_i;
            end
        end
    end

    // Present the addressed bank's record.
    always_comb begin
        look_open_o = open_o[look_bank_i];
        look_row_o  = row_q[look_bank_i];
    end

endmodule

// File: rtl/dpt_page_array.sv
// Module dpt_page_array
// Behavioural octbyte store with one word per bank, row and column. Builds
// the write enable from the mask options, merges it with the old word, and
// returns read data registered (zero when no read). Assumes the address is
// a plain concatenation, so rows and columns are powers of two.
module dpt_page_array
    import dpt_pkg::*;
#(
    parameter  int DEPTH = 128,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [AW-1:0]       addr_i,
    input  logic                rd_en_i,
    input  logic                wr_en_i,
    input  logic                mask_en_i,
    input  logic                bit_mask_i,
    input  logic [OCT_BITS-1:0] wdata_i,
    input  logic [OCT_BITS-1:0] mask_i,
    output logic [OCT_BITS-1:0] rdata_o
);

    logic [OCT_BITS-1:0] mem [DEPTH];
    logic [OCT_BITS-1:0] byte_en;
    logic [OCT_BITS-1:0] wen;
    logic [OCT_BITS-1:0] old_word;

    for (genvar i = 0; i < OCT_BYTES; i++) begin : g_byte
        assign byte_en[i*8 +: 8] = {8{mask_i[i]}};
    end

    // Pick full, byte-expanded or per-bit enables.
    always_comb begin
        if (!mask_en_i)      wen = '1;
        else if (bit_mask_i) wen = mask_i;
        else                 wen = byte_en;
        old_word = mem[addr_i];
    end

    // Merge enabled bits of the write data into the stored word.
    always_ff @(posedge clk) begin
        if (wr_en_i) mem[addr_i] <= (old_word & ~wen) | (wdata_i & wen);
    end

    // Register read data; zero on anything but a read.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_o <= '0;
        else if (rd_en_i) rdata_o <= old_word;
        else              rdata_o <= '0;
    end

    // Disabled bits of a write keep their previous contents (R11, R12).
    assert_masked_bits_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((mem[$past(addr_i)] & ~$past(wen)) == ($past(old_word) & ~$past(wen))));

endmodule

// File: rtl/dram_page_tracker.sv
// Module dram_page_tracker
// Top of the page state tracker. Decodes each command, compares its row with
// the bank's open row to decide hit, activate or precharge-plus-activate,
// updates the bank record (closing it on auto-precharge), performs the column
// access and registers a response one clock later. Assumes the caller drives
// commands only after reset is released.
module dram_page_tracker
    import dpt_pkg::*;
#(
    parameter  int NUM_BANKS = 2,
    parameter  int ROWS      = 16,
    parameter  int COLS      = 4,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ROW_W     = $clog2(ROWS),
    localparam int COL_W     = $clog2(COLS),
    localparam int DEPTH     = NUM_BANKS * ROWS * COLS,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic                 cmd_actv,
    input  logic                 cmd_auto,
    input  logic [5:0]           cmd_op,
    input  logic [BANK_W-1:0]    cmd_bank,
    input  logic [ROW_W-1:0]     cmd_row,
    input  logic [COL_W-1:0]     cmd_col,
    input  logic [63:0]          wr_data,
    input  logic [63:0]          wr_mask,
    output logic                 rsp_valid,
    output logic [2:0]           rsp_class,
    output logic                 rsp_pre,
    output logic                 rsp_act,
    output logic                 rsp_hit,
    output logic                 rsp_err,
    output logic [63:0]          rsp_rdata,
    output logic [NUM_BANKS-1:0] bank_open
);

    dec_t             dec;
    logic             is_open;
    logic [ROW_W-1:0] open_row;
    logic             col_cmd;
    logic             same_row;
    logic             miss_err;
    logic             go;
    logic             hit_n, act_n, pre_n;
    logic [ROW_W-1:0] eff_row;
    logic [AW-1:0]    addr;

    dpt_cmd_decode u_dec (
        .actv_i (cmd_actv),
        .auto_i (cmd_auto),
        .op_i   (cmd_op),
        .dec_o  (dec)
    );

    dpt_bank_table #(
        .NUM_BANKS (NUM_BANKS),
        .ROW_W     (ROW_W)
    ) u_banks (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_bank_i (cmd_bank),
        .look_open_o (is_open),
        .look_row_o  (open_row),
        .upd_en_i    (go),
        .upd_bank_i  (cmd_bank),
        .upd_open_i  (!cmd_auto),
        .upd_row_i   (eff_row),
        .open_o      (bank_open)
    );

    // Judge the page state of the addressed bank for this command.
    always_comb begin
        col_cmd  = (dec.cls == CLS_READ) || (dec.cls == CLS_WRITE);
        same_row = is_open && (open_row == cmd_row);
        miss_err = col_cmd && !cmd_actv && !is_open;
        go       = cmd_valid && col_cmd && !miss_err;
        hit_n    = go && (cmd_actv ? same_row : 1'b1);
        act_n    = go && cmd_actv && !same_row;
        pre_n    = go && cmd_actv && is_open && !same_row;
        eff_row  = cmd_actv ? cmd_row : open_row;
        addr     = AW'({cmd_bank, eff_row, cmd_col});
    end

    dpt_page_array #(
        .DEPTH (DEPTH)
    ) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .rd_en_i    (go && dec.cls == CLS_READ),
        .wr_en_i    (go && dec.cls == CLS_WRITE),
        .mask_en_i  (dec.mask_en),
        .bit_mask_i (dec.bit_mask),
        .wdata_i    (wr_data),
        .mask_i     (wr_mask),
        .rdata_o    (rsp_rdata)
    );

    // Register the response flags for the accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_class <= 3'd0;
            rsp_pre   <= 1'b0;
            rsp_act   <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_class <= cmd_valid ? 3'(dec.cls) : 3'd0;
            rsp_pre   <= pre_n;
            rsp_act   <= act_n;
            rsp_hit   <= hit_n;
            rsp_err   <= cmd_valid && ((dec.cls == CLS_ILLEGAL) || miss_err);
        end
    end

    // A response only follows an accepted command (R1).
    assert_rsp_follows_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid);

    // A precharge is always followed by an activate (R5).
    assert_pre_implies_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_pre |-> rsp_act);

    // A page hit never needs an activate (R4).
    assert_hit_excludes_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_hit && rsp_act));

    // Errors leave every bank record unchanged (R7).
    assert_err_keeps_banks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (bank_open == $past(bank_open)));

    // Register accesses leave every bank record unchanged (R13).
    assert_reg_keeps_banks_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_class == 3'd2 || rsp_class == 3'd3)) |->
        (bank_open == $past(bank_open)));

    // Auto-precharge closes the addressed bank (R8).
    assert_auto_closes_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && col_cmd && !miss_err && cmd_auto) |=> !bank_open[$past(cmd_bank)]);

endmodule

// File: tb/dram_page_tracker_tb_top.sv
`timescale 1ns/1ps
module dram_page_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_actv = 1'b0;
    logic        cmd_auto = 1'b0;
    logic [5:0]  cmd_op = '0;
    logic [0:0]  cmd_bank = '0;
    logic [3:0]  cmd_row = '0;
    logic [1:0]  cmd_col = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] wr_mask = '0;
    logic        rsp_valid;
    logic [2:0]  rsp_class;
    logic        rsp_pre, rsp_act, rsp_hit, rsp_err;
    logic [63:0] rsp_rdata;
    logic [1:0]  bank_open;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    dram_page_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_actv(cmd_actv),
        .cmd_auto(cmd_auto), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .wr_data(wr_data),
        .wr_mask(wr_mask), .rsp_valid(rsp_valid), .rsp_class(rsp_class),
        .rsp_pre(rsp_pre), .rsp_act(rsp_act), .rsp_hit(rsp_hit),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bank_open(bank_open)
    );

    localparam logic [5:0] OP_RD    = 6'b000000;
    localparam logic [5:0] OP_WR    = 6'b000001;
    localparam logic [5:0] OP_WRBY  = 6'b010001;
    localparam logic [5:0] OP_WRBIT = 6'b010101;
    localparam logic [5:0] OP_RR    = 6'b000110;
    localparam logic [5:0] OP_RW    = 6'b001111;
    localparam logic [5:0] OP_BAD   = 6'b001000;
    localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_RR = 3'd2, C_RW = 3'd3, C_IL = 3'd4;
    localparam logic [63:0] DA = 64'h1111_2222_3333_4444;
    localparam logic [63:0] M1 = 64'h1111_2222_FFFF_FFFF;
    localparam logic [63:0] M2 = 64'h0111_2222_FFFF_FFF0;
    localparam logic [63:0] DB = 64'hABCD_EF01_2345_6789;
    localparam logic [63:0] DC = 64'hC0FF_EE00_1234_5678;
    localparam logic [63:0] Z  = 64'h0;

    // flags are {pre, act, hit, err}
    typedef struct packed {
        logic        a;
        logic        u;
        logic [5:0]  op;
        logic [0:0]  bk;
        logic [3:0]  row;
        logic [1:0]  col;
        logic [63:0] wd;
        logic [63:0] wm;
        logic [2:0]  ecls;
        logic [3:0]  efl;
        logic [63:0] erd;
        logic [1:0]  eopen;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,OP_WR,   1'b0,4'd3,2'd1,DA,   Z,      C_WR,4'b0100,Z, 2'b01,4'd3},  // R3 activate idle bank
        '{1'b1,1'b0,OP_RD,   1'b0,4'd3,2'd1,Z,    Z,      C_RD,4'b0010,DA,2'b01,4'd9},  // R4 R9 hit and read back
        '{1'b0,1'b0,OP_RD,   1'b0,4'd9,2'd1,Z,    Z,      C_RD,4'b0010,DA,2'b01,4'd6},  // R6 row ignored
        '{1'b0,1'b0,OP_WRBY, 1'b0,4'd0,2'd1,{64{1'b1}},64'h0F,C_WR,4'b0010,Z,2'b01,4'd11}, // R11 byte mask
        '{1'b0,1'b0,OP_RD,   1'b0,4'd0,2'd1,Z,    Z,      C_RD,4'b0010,M1,2'b01,4'd11},
        '{1'b0,1'b0,OP_WRBIT,1'b0,4'd0,2'd1,Z,64'hF000_0000_0000_000F,C_WR,4'b0010,Z,2'b01,4'd12}, // R12 bit mask
        '{1'b0,1'b0,OP_RD,   1'b0,4'd0,2'd1,Z,    Z,      C_RD,4'b0010,M2,2'b01,4'd12},
        '{1'b1,1'b0,OP_WR,   1'b0,4'd5,2'd1,DB,   Z,      C_WR,4'b1100,Z, 2'b01,4'd5},  // R5 row conflict
        '{1'b0,1'b0,OP_RD,   1'b0,4'd0,2'd1,Z,    Z,      C_RD,4'b0010,DB,2'b01,4'd10}, // R10 full write, mask ignored
        '{1'b0,1'b0,OP_RD,   1'b1,4'd3,2'd1,Z,    Z,      C_RD,4'b0001,Z, 2'b01,4'd7},  // R7 idle bank read
        '{1'b0,1'b0,OP_WR,   1'b1,4'd3,2'd1,DC,   Z,      C_WR,4'b0001,Z, 2'b01,4'd7},  // R7 idle bank write
        '{1'b1,1'b1,OP_WR,   1'b1,4'd3,2'd1,DC,   Z,      C_WR,4'b0100,Z, 2'b01,4'd8},  // R8 auto closes
        '{1'b1,1'b0,OP_RD,   1'b1,4'd3,2'd1,Z,    Z,      C_RD,4'b0100,DC,2'b11,4'd14}, // R14 bank 1 storage
        '{1'b1,1'b0,OP_RD,   1'b0,4'd3,2'd1,Z,    Z,      C_RD,4'b1100,M2,2'b11,4'd14}, // R14 bank 0 kept
        '{1'b0,1'b0,OP_RR,   1'b0,4'd0,2'd0,Z,    Z,      C_RR,4'b0000,Z, 2'b11,4'd13}, // R13 reg read
        '{1'b0,1'b0,OP_RW,   1'b0,4'd0,2'd0,Z,    Z,      C_RW,4'b0000,Z, 2'b11,4'd13}, // R13 reg write
        '{1'b1,1'b0,OP_RR,   1'b0,4'd0,2'd0,Z,    Z,      C_IL,4'b0001,Z, 2'b11,4'd2},  // R2 reg with activate
        '{1'b0,1'b0,OP_BAD,  1'b0,4'd0,2'd1,Z,    Z,      C_IL,4'b0001,Z, 2'b11,4'd2},  // R2 reserved read bits
        '{1'b0,1'b1,OP_RD,   1'b0,4'd0,2'd1,Z,    Z,      C_RD,4'b0010,M2,2'b10,4'd8},  // R8 read with auto
        '{1'b0,1'b0,OP_WR,   1'b0,4'd3,2'd1,DA,   Z,      C_WR,4'b0001,Z, 2'b10,4'd7},  // R7 no write done
        '{1'b1,1'b0,OP_RD,   1'b0,4'd3,2'd1,Z,    Z,      C_RD,4'b0100,M2,2'b11,4'd7}   // R7 data unchanged
    };

    task automatic ck(input string req, input string what,
                      input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic send(input vec_t v);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_actv  = v.a;
        cmd_auto  = v.u;
        cmd_op    = v.op;
        cmd_bank  = v.bk;
        cmd_row   = v.row;
        cmd_col   = v.col;
        wr_data   = v.wd;
        wr_mask   = v.wm;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        ck("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
        ck("R1", "bank_open in reset", 64'(bank_open), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        ck("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        ck("R1", "bank_open after reset", 64'(bank_open), 64'd0);

        for (int i = 0; i < NV; i++) begin
            string r;
            r = $sformatf("R%0d", VECS[i].req);
            send(VECS[i]);
            ck(r, $sformatf("v%0d valid", i), 64'(rsp_valid), 64'd1);
            ck(r, $sformatf("v%0d class", i), 64'(rsp_class), 64'(VECS[i].ecls));
            ck(r, $sformatf("v%0d flags", i),
               64'({rsp_pre, rsp_act, rsp_hit, rsp_err}), 64'(VECS[i].efl));
            ck(r, $sformatf("v%0d rdata", i), rsp_rdata, VECS[i].erd);
            ck(r, $sformatf("v%0d bank_open", i), 64'(bank_open), 64'(VECS[i].eopen));
        end

        // R1: idle clock gives no response
        @(negedge clk);
        @(posedge clk);
        #1;
        ck("R1", "idle rsp_valid", 64'(rsp_valid), 64'd0);

        // R1: reset mid-run closes all banks
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        ck("R1", "mid-run reset bank_open", 64'(bank_open), 64'd0);
        ck("R1", "mid-run reset rsp_valid", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R7: after reset a non-activating read errors
        send('{1'b0,1'b0,OP_RD,1'b0,4'd3,2'd1,Z,Z,C_RD,4'b0001,Z,2'b00,4'd1});
        ck("R1", "post-reset read err", 64'(rsp_err), 64'd1);
        ck("R7", "post-reset read rdata", rsp_rdata, 64'd0);

        // R3 R9: data survives reset in the array; activate reopens
        send('{1'b1,1'b0,OP_RD,1'b0,4'd3,2'd1,Z,Z,C_RD,4'b0100,Z,2'b01,4'd3});
        ck("R3", "reopen act flag", 64'(rsp_act), 64'd1);
        ck("R9", "reopen rdata", rsp_rdata, M2);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule